// File: doc/BRIEF.md
# Edge-Counting Pulse Accumulator

This block counts transitions on a single asynchronous input pin in an 8-bit counter. It takes the pin through a synchroniser, detects either rising or falling transitions as chosen by a mode input, and advances the counter by one for each detected transition. Two sticky status flags are kept: one that records any counted transition and one that records the counter wrapping from its all-ones value back to zero.

Software reaches the block through a simple register bus. It can read and load the counter, enable interrupts, and poll and clear the flags. The enable bits live in a timer mask register and the flags live in a timer flag register. Both registers also hold bits that belong to neighbouring timer functions; those bits are stored or read as zero. The flags are cleared by writing ones. A single level interrupt request is raised while any flag is set together with its enable.

Top module: `pulse_accum`

## Requirements
- R1: After reset the counter reads 0x00, the mask register reads 0x00, the flag register reads 0x00 and `irq` is 0.
- R2: With `rise_sel` = 1, each low-to-high transition of `pin_in` adds one to the counter, and high-to-low transitions add nothing.
- R3: With `rise_sel` = 0, each high-to-low transition of `pin_in` adds one to the counter, and low-to-high transitions add nothing.
- R4: Each counted transition sets the edge flag, which is bit 4 of the flag register at offset 0x25.
- R5: A counted transition that takes the counter from 0xFF to 0x00 sets the wrap flag, which is bit 5 of the flag register. No other transition sets it.
- R6: A write to offset 0x25 clears each of bits 5 and 4 whose written data bit is 1. A written 0, or a write to any other data bit, leaves the flag unchanged.
- R7: When a flag is set by hardware in the same cycle as a write of 1 to its bit, the flag ends up set.
- R8: The mask register at offset 0x24 holds the wrap interrupt enable at bit 5 and the edge interrupt enable at bit 4. One clock after a flag and its enable are both 1, `irq` is 1. `irq` drops one clock after no flag has its enable set. Changing the enables never changes the flags.
- R9: Mask register bits 7, 6, 1 and 0 are plain storage, and its bits 3 and 2 read 0. Flag register bits 7, 6 and 3 to 0 read 0, even after a write of ones.
- R10: A write to offset 0x27 loads the written byte into the counter. It takes precedence over a counted transition in the same cycle, and that transition still sets the edge flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous pulse input |
| rise_sel | input | 1 | 1 counts rising transitions, 0 counts falling ones |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_sel`; 0 when not selected |
| irq | output | 1 | Registered level interrupt request |

## Verification
A table of pulse trains is run in both polarities. Each train is a number of complete high-low pulses, optionally followed by a trailing rise. Complete pulses give the same count in either mode, while a trailing rise adds one only in rising mode. That trailing rise is what separates the two polarities. Preloads of 0xFE, 0xFF and values far from the wrap show whether the wrap flag follows the roll-over and nothing else. Directed sequences then place a flag-clearing write and a counter load on exactly the cycle in which a transition lands. These expose the set-versus-clear and load-versus-increment priorities. They also walk the enable combinations to tell interrupt gating apart from flag state.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned OFS_MASK = 'h24;
   localparam int unsigned OFS_FLAG = 'h25;
   localparam int unsigned OFS_CNT  = 'h27;
   localparam int unsigned BIT_WRAP = 5;
   localparam int unsigned BIT_EDGE = 4;
   localparam logic [REG_W-1:0] MASK_STORE = 8'hF3;
endpackage

// File: rtl/pacc_edge.sv
module pacc_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pacc_edge: STAGES must be at least 2");
      end
   endgenerate

   logic stage_q [STAGES];
   logic last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= 1'b0;
            else        stage_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   logic settled;
   assign settled = stage_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= settled;
   end

   always_comb begin
      if (rise_sel) hit = settled & ~last_q;
      else          hit = ~settled & last_q;
   end

   // R2 / R3: a transition is reported for one cycle only
   assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (!hit || rise_sel != $past(rise_sel)));
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pacc_counter: CNT_W must be positive");
      end
   endgenerate

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   assign wrap = inc & ~load & (cnt == TOP);

   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> cnt == $past(cnt) + 1'b1);
   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/pacc_regs.sv
module pacc_regs
   import pacc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              set_wrap,
   input  logic              set_edge,
   output logic              load_cnt,
   output logic [CNT_W-1:0]  load_val,
   output logic              wrap_flag,
   output logic              edge_flag,
   output logic              irq
);
   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("pacc_regs: ADDR_W must reach offset 0x27");
      end
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("pacc_regs: CNT_W must fit the data bus");
      end
   endgenerate

   logic hit_mask, hit_flag, hit_cnt, wr_mask, wr_flag;
   logic [REG_W-1:0] mask_q;
   logic clr_wrap, clr_edge;

   assign hit_mask = bus_addr == ADDR_W'(OFS_MASK);
   assign hit_flag = bus_addr == ADDR_W'(OFS_FLAG);
   assign hit_cnt  = bus_addr == ADDR_W'(OFS_CNT);
   assign wr_mask  = bus_sel & bus_wr & hit_mask;
   assign wr_flag  = bus_sel & bus_wr & hit_flag;
   assign load_cnt = bus_sel & bus_wr & hit_cnt;
   assign load_val = bus_wdata[CNT_W-1:0];
   assign clr_wrap = wr_flag & bus_wdata[BIT_WRAP];
   assign clr_edge = wr_flag & bus_wdata[BIT_EDGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata & MASK_STORE;
   end

   // hardware set takes precedence over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrap_flag <= 1'b0;
         edge_flag <= 1'b0;
      end else begin
         if (set_wrap)      wrap_flag <= 1'b1;
         else if (clr_wrap) wrap_flag <= 1'b0;
         if (set_edge)      edge_flag <= 1'b1;
         else if (clr_edge) edge_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (wrap_flag & mask_q[BIT_WRAP]) | (edge_flag & mask_q[BIT_EDGE]);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_mask) bus_rdata = mask_q;
         if (hit_flag) begin
            bus_rdata[BIT_WRAP] = wrap_flag;
            bus_rdata[BIT_EDGE] = edge_flag;
         end
         if (hit_cnt)  bus_rdata = REG_W'(cnt);
      end
   end

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_edge || set_wrap) |=> (($past(set_edge) -> edge_flag) && ($past(set_wrap) -> wrap_flag)));
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_edge && !set_edge) |=> !edge_flag);
   assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_flag && wrap_flag && !clr_edge && !clr_wrap) |=> (edge_flag && wrap_flag));
   assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (hit_mask || hit_flag)) |-> bus_rdata[3:2] == 2'b00);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
   import pacc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic              rise_sel,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq
);
   logic             hit, wrap, load_cnt, wrap_flag, edge_flag;
   logic [CNT_W-1:0] cnt, load_val;

   pacc_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise_sel(rise_sel), .hit(hit)
   );

   pacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(hit), .load(load_cnt),
      .load_val(load_val), .cnt(cnt), .wrap(wrap)
   );

   pacc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .set_wrap(wrap), .set_edge(hit), .load_cnt(load_cnt),
      .load_val(load_val), .wrap_flag(wrap_flag), .edge_flag(edge_flag), .irq(irq)
   );

   assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_flag) |-> cnt == '0);
   assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> edge_flag);
   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap_flag && !edge_flag) |=> !irq);
   assert_reset_R1: assert property (@(posedge clk) !rst_n |-> (cnt == '0 && !irq));
endmodule

// File: tb/pulse_accum_tb.sv
`timescale 1ns/1ps
module pulse_accum_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b0;
   logic       rise_sel = 1'b1;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pulse_accum dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise_sel(rise_sel),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [5:0] A_MASK = 6'h24, A_FLAG = 6'h25, A_CNT = 6'h27;

   // {sel, pulses[8], tail, preload[8], exp_cnt[8], exp_wrap, exp_edge}
   localparam logic [27:0] VEC [7] = '{
      {1'b1, 8'd3, 1'b0, 8'h00, 8'h03, 1'b0, 1'b1},
      {1'b1, 8'd2, 1'b1, 8'h0A, 8'h0D, 1'b0, 1'b1},
      {1'b0, 8'd2, 1'b1, 8'h0A, 8'h0C, 1'b0, 1'b1},
      {1'b0, 8'd0, 1'b1, 8'h05, 8'h05, 1'b0, 1'b0},
      {1'b1, 8'd1, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1},
      {1'b0, 8'd3, 1'b0, 8'hFE, 8'h01, 1'b1, 1'b1},
      {1'b1, 8'd0, 1'b0, 8'h80, 8'h80, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      @(negedge clk); pin_in = 1'b1; idle(3);
      pin_in = 1'b0; idle(3);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(A_CNT, v);  check("R1 count", v, 8'h00);
      rd(A_MASK, v); check("R1 mask", v, 8'h00);
      rd(A_FLAG, v); check("R1 flags", v, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);

      // table of pulse trains, both polarities
      for (int i = 0; i < 7; i++) begin
         logic [27:0] e;
         e = VEC[i];
         pin_in = 1'b0; idle(5);
         rise_sel = e[27]; idle(2);
         wr(A_CNT, e[17:10]);
         wr(A_FLAG, 8'h30);
         for (int p = 0; p < int'(e[26:19]); p++) pulse();
         if (e[18]) begin @(negedge clk); pin_in = 1'b1; end
         idle(6);
         rd(A_CNT, v);
         check(e[27] ? "R2 rising count" : "R3 falling count", v, e[9:2]);
         rd(A_FLAG, v);
         check("R5 wrap flag", {7'd0, v[5]}, {7'd0, e[1]});
         check("R4 edge flag", {7'd0, v[4]}, {7'd0, e[0]});
         check("R8 irq masked", {7'd0, irq}, 8'h00);
      end
      pin_in = 1'b0; idle(5);
      rise_sel = 1'b1; idle(2);
      wr(A_FLAG, 8'h30);

      // R9 reserved and stored bits
      wr(A_MASK, 8'hFF); rd(A_MASK, v); check("R9 mask storage", v, 8'hF3);
      wr(A_FLAG, 8'hFF); rd(A_FLAG, v); check("R9 flag reserved", v, 8'h00);
      wr(A_MASK, 8'h00); rd(A_MASK, v); check("R9 mask clear", v, 8'h00);

      // R6 write-one-to-clear
      wr(A_CNT, 8'hFF); pulse(); idle(3);
      rd(A_FLAG, v); check("R6 both set", v, 8'h30);
      wr(A_FLAG, 8'h00); rd(A_FLAG, v); check("R6 zero keeps", v, 8'h30);
      wr(A_FLAG, 8'hCF); rd(A_FLAG, v); check("R6 other bits keep", v, 8'h30);
      wr(A_FLAG, 8'h20); rd(A_FLAG, v); check("R6 clear wrap only", v, 8'h10);
      wr(A_FLAG, 8'h10); rd(A_FLAG, v); check("R6 clear edge", v, 8'h00);

      // R8 interrupt gating
      pulse(); idle(3);
      check("R8 no enable", {7'd0, irq}, 8'h00);
      wr(A_MASK, 8'h20); idle(3);
      check("R8 wrong enable", {7'd0, irq}, 8'h00);
      rd(A_FLAG, v); check("R8 enable leaves flags", v, 8'h10);
      wr(A_MASK, 8'h10); idle(3);
      check("R8 edge irq", {7'd0, irq}, 8'h01);
      wr(A_MASK, 8'h00); idle(3);
      check("R8 disable drops irq", {7'd0, irq}, 8'h00);
      rd(A_FLAG, v); check("R8 disable leaves flags", v, 8'h10);
      wr(A_MASK, 8'h10); idle(2);
      wr(A_FLAG, 8'h10); idle(3);
      check("R8 clear drops irq", {7'd0, irq}, 8'h00);
      wr(A_CNT, 8'hFF); pulse(); wr(A_FLAG, 8'h10);
      wr(A_MASK, 8'h20); idle(3);
      check("R8 wrap irq", {7'd0, irq}, 8'h01);
      wr(A_MASK, 8'h00); wr(A_FLAG, 8'h30); idle(3);

      // R7 set beats a same-cycle clear
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h10;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
      idle(2);
      rd(A_FLAG, v); check("R7 set wins", v, 8'h10);
      pin_in = 1'b0; idle(5);
      wr(A_FLAG, 8'h30);

      // R10 load beats a same-cycle increment
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h42;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
      idle(2);
      rd(A_CNT, v);  check("R10 load wins", v, 8'h42);
      rd(A_FLAG, v); check("R10 edge still flagged", v, 8'h10);
      pin_in = 1'b0; idle(5);

      done = 1;
      summary();
      $finish;
   end
endmodule